// File: doc/BRIEF.md
# Consecutive-Channel Conversion Sequencer

This block decides which of four input channels the converter samples on each frame. It follows the two fields of the control word that matter for channel choice: a two-bit channel address and a two-bit sequence code. In single-channel operation the output is simply the programmed address. In sequence operation the block walks upward from channel 0 to a final channel taken from the address field. It then wraps back to channel 0 and repeats for as long as the sequence runs.

The surrounding serial logic gives the block two inputs. The first is a one-cycle strobe for each conversion frame. The second is a one-cycle pulse when a control word has been committed, with the decoded address and sequence code beside it. `chan_o` always shows the channel the next frame will convert, and the output framing also uses it as the channel tag. A frame strobe moves the pointer on once that frame has taken its channel. A committed word takes effect on the cycle after its pulse.

Top module: `chan_sequencer`

## Requirements
- R1: After reset the block is in single-channel mode and `chan_o` is 0.
- R2: A commit with sequence code `seq_i` = 2'b00 or 2'b01, or with 2'b10 when no sequence is running, sets `chan_o` to `addr_i` on the next cycle. In single-channel mode, frame strobes leave `chan_o` unchanged.
- R3: A commit with `seq_i` = 2'b11 starts a sequence. Its final channel is `addr_i`, and `chan_o` is 0 on the next cycle, so the first frame converts channel 0.
- R4: While a sequence runs, each frame strobe whose channel is below the final channel raises `chan_o` by exactly one.
- R5: While a sequence runs, a frame strobe on the final channel returns `chan_o` to 0, and the cycle repeats indefinitely.
- R6: While a sequence runs, a cycle with no frame strobe and no commit leaves `chan_o` unchanged.
- R7: A commit with `seq_i` = 2'b10 during a running sequence neither stops it nor changes its final channel. Its `addr_i` is ignored.
- R8: A commit with `seq_i` = 2'b00 or 2'b01 during a running sequence ends it. `chan_o` becomes `addr_i`, and later frames no longer advance it.
- R9: A commit with `seq_i` = 2'b11 during a running sequence restarts it at channel 0, with the new `addr_i` as its final channel.
- R10: If a commit and a frame strobe arrive in the same cycle, a commit that stops or restarts the sequence takes precedence. A 2'b10 commit during a running sequence lets the frame advance the channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_i | input | 1 | One-cycle strobe per conversion frame |
| commit_i | input | 1 | One-cycle pulse: a control word was committed |
| addr_i | input | 2 | Channel address field of the committed word |
| seq_i | input | 2 | Sequence code field of the committed word (bit 1 first) |
| chan_o | output | 2 | Channel for the next frame, also used as the channel tag |

## Verification
The assertions assume that `addr_i` and `seq_i` are meaningful only in a cycle where `commit_i` is high. They also assume that `frame_i` and `commit_i` are single-cycle strobes that may coincide. Any 2-bit address is legal, including a final channel of 0, which makes a one-channel sequence. The stimulus drives random fields on every cycle, so values present without a commit are shown to be ignored. It mixes coincident strobes, long idle gaps and every sequence code, and it starts with directed runs through the wrap-around, restart and stop cases.

// File: rtl/chseq_pkg.sv
package chseq_pkg;
  typedef enum logic [1:0] {
    SEQ_PICK_A = 2'b00,
    SEQ_PICK_B = 2'b01,
    SEQ_KEEP   = 2'b10,
    SEQ_START  = 2'b11
  } seq_code_e;
endpackage

// File: rtl/chseq_cmd_decode.sv
module chseq_cmd_decode
  import chseq_pkg::*;
(
  input  logic       commit_i,
  input  logic [1:0] seq_i,
  input  logic       running_i,
  output logic       start_o,
  output logic       select_o,
  output logic       keep_o
);
  seq_code_e code;

  always_comb begin
    code     = seq_code_e'(seq_i);
    start_o  = 1'b0;
    select_o = 1'b0;
    keep_o   = 1'b0;
    if (commit_i) begin
      unique case (code)
        SEQ_START: start_o = 1'b1;
        SEQ_KEEP: begin
          keep_o   = running_i;
          select_o = !running_i;
        end
        default:   select_o = 1'b1;
      endcase
    end
  end

  always_comb begin
    assert_cmd_exclusive_R10: assert ($onehot0({start_o, select_o, keep_o}))
      else $error("command decode not exclusive");
  end
endmodule

// File: rtl/chseq_step.sv
module chseq_step #(
  parameter int N_CH = 4,
  localparam int CW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [CW-1:0] chan_i,
  input  logic [CW-1:0] last_i,
  output logic [CW-1:0] next_o,
  output logic          wrap_o
);
  always_comb begin
    wrap_o = (chan_i == last_i) || (chan_i == CW'(N_CH - 1));
    next_o = wrap_o ? '0 : chan_i + CW'(1);
  end
endmodule

// File: rtl/chan_sequencer.sv
module chan_sequencer #(
  parameter int N_CH = 4,
  localparam int CW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic          commit_i,
  input  logic [CW-1:0] addr_i,
  input  logic [1:0]    seq_i,
  output logic [CW-1:0] chan_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_n;
  logic          run_q, run_d;
  logic [CW-1:0] last_q, last_d;
  logic [CW-1:0] chan_q, chan_d;
  logic          cmd_start, cmd_select, cmd_keep;
  logic [CW-1:0] step_chan;
  logic          step_wrap;
  logic          chan_en, last_en;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  chseq_cmd_decode u_decode (
    .commit_i  (commit_i),
    .seq_i     (seq_i),
    .running_i (run_q),
    .start_o   (cmd_start),
    .select_o  (cmd_select),
    .keep_o    (cmd_keep)
  );

  chseq_step #(.N_CH(N_CH)) u_step (
    .chan_i (chan_q),
    .last_i (last_q),
    .next_o (step_chan),
    .wrap_o (step_wrap)
  );

  always_comb begin
    run_d   = run_q;
    last_d  = last_q;
    chan_d  = chan_q;
    last_en = 1'b0;
    chan_en = 1'b0;
    if (cmd_start) begin
      run_d   = 1'b1;
      last_d  = addr_i;
      last_en = 1'b1;
      chan_d  = '0;
      chan_en = 1'b1;
    end else if (cmd_select) begin
      run_d   = 1'b0;
      chan_d  = addr_i;
      chan_en = 1'b1;
    end else if (frame_i && run_q) begin
      chan_d  = step_chan;
      chan_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      last_q <= '0;
      chan_q <= '0;
    end else begin
      run_q <= run_d;
      if (last_en) last_q <= last_d;
      if (chan_en) chan_q <= chan_d;
    end
  end

  assign chan_o = chan_q;

  assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i && seq_i == 2'b11 |=> chan_o == '0 && run_q)
    else $error("start/restart did not go to channel 0");

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && frame_i && !commit_i && chan_o != last_q |=> chan_o == $past(chan_o) + CW'(1))
    else $error("sequence did not step up by one");

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && frame_i && !commit_i && chan_o == last_q |=> chan_o == '0)
    else $error("sequence did not wrap to channel 0");

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i && !commit_i |=> $stable(chan_o) && $stable(run_q))
    else $error("state changed without a frame or commit");

  assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && commit_i && seq_i == 2'b10 |=> run_q && $stable(last_q))
    else $error("keep code disturbed the sequence");

  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i && seq_i[1] == 1'b0 |=> !run_q && chan_o == $past(addr_i))
    else $error("single-channel code did not select the address");

  assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> chan_o <= last_q)
    else $error("sequence channel beyond final channel");
endmodule

// File: tb/test_chan_sequencer.sv
module test_chan_sequencer;
  logic       clk;
  logic       rst_ni;
  logic       frame_i, commit_i;
  logic [1:0] addr_i, seq_i;
  logic [1:0] chan_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit       m_run;
  bit [1:0] m_last, m_chan;

  chan_sequencer i_chan_sequencer (
    .clk(clk), .rst_ni(rst_ni), .frame_i(frame_i), .commit_i(commit_i),
    .addr_i(addr_i), .seq_i(seq_i), .chan_o(chan_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit [1:0] advance(bit [1:0] c, bit [1:0] l);
    return (c == l) ? 2'd0 : c + 2'd1;
  endfunction

  // Applies one cycle of stimulus to the model; returns the requirement exercised.
  function automatic string model_step(bit f, bit w, bit [1:0] a, bit [1:0] s);
    string tag;
    if (w && s == 2'b11) begin
      tag = m_run ? (f ? "R10" : "R9") : "R3";
      m_run = 1; m_last = a; m_chan = 2'd0;
    end else if (w && s == 2'b10 && m_run) begin
      tag = f ? "R10" : "R7";
      if (f) m_chan = advance(m_chan, m_last);
    end else if (w) begin
      tag = m_run ? (f ? "R10" : "R8") : "R2";
      m_run = 0; m_chan = a;
    end else if (f && m_run) begin
      tag = (m_chan == m_last) ? "R5" : "R4";
      m_chan = advance(m_chan, m_last);
    end else begin
      tag = m_run ? "R6" : "R2";
    end
    return tag;
  endfunction

  task automatic check(string tag, bit [1:0] exp);
    checks++;
    if (chan_o !== exp) begin
      failures++;
      $display("FAIL %s chan_o actual=%0d expected=%0d", tag, chan_o, exp);
    end
  endtask

  task automatic cyc(bit f, bit w, bit [1:0] a, bit [1:0] s);
    string tag;
    frame_i = f; commit_i = w; addr_i = a; seq_i = s;
    @(posedge clk);
    #5;
    tag = model_step(f, w, a, s);
    check(tag, m_chan);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC0_0042));
    frame_i = 0; commit_i = 0; addr_i = 2'd3; seq_i = 2'b11;
    rst_ni = 1'b0;
    m_run = 0; m_last = 0; m_chan = 0;
    repeat (3) @(posedge clk);
    #5 rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    #5 check("R1", 2'd0);
    // R2 single selection, frames do not move it
    cyc(0, 1, 2'd3, 2'b00);
    cyc(1, 0, 2'd0, 2'b11);
    cyc(0, 1, 2'd1, 2'b01);
    cyc(0, 1, 2'd2, 2'b10);
    cyc(1, 0, 2'd1, 2'b00);
    // R3 start with final 2, R4/R5 walk and wrap
    cyc(0, 1, 2'd2, 2'b11);
    for (int i = 0; i < 7; i++) cyc(1, 0, 2'd3, 2'b01);
    cyc(0, 0, 2'd3, 2'b01);
    // R7 keep code ignores address
    cyc(0, 1, 2'd3, 2'b10);
    for (int i = 0; i < 4; i++) cyc(1, 0, 2'd0, 2'b00);
    // R10 keep with frame advances
    cyc(1, 1, 2'd0, 2'b10);
    // R9 restart with final 3
    cyc(1, 1, 2'd3, 2'b11);
    for (int i = 0; i < 5; i++) cyc(1, 0, 2'd1, 2'b00);
    // final channel 0: one-channel sequence
    cyc(0, 1, 2'd0, 2'b11);
    for (int i = 0; i < 3; i++) cyc(1, 0, 2'd2, 2'b00);
    // R8 stop, then frames stay
    cyc(0, 1, 2'd3, 2'b11);
    cyc(1, 0, 2'd0, 2'b00);
    cyc(0, 1, 2'd2, 2'b01);
    cyc(1, 0, 2'd0, 2'b11);
    // R10 stop code together with frame
    cyc(0, 1, 2'd3, 2'b11);
    cyc(1, 0, 2'd0, 2'b00);
    cyc(1, 1, 2'd1, 2'b00);
    for (int i = 0; i < 4000; i++) begin
      bit f, w;
      f = ($urandom_range(0, 9) < 4);
      w = ($urandom_range(0, 19) < 3);
      cyc(f, w, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule